// File: doc/BRIEF.md
# Gray-Scale Row Drive Timing Sequencer

This block produces the timing of one row period for a passive-matrix column driver with 4-bit gray levels. An oscillator tick is divided down to a display clock. Every row period, counted in display clocks, splits into four phases in fixed order: a reset phase, a first pre-charge phase, a second pre-charge phase and a current-drive phase. During current drive, each column's enable stays high for a number of display clocks read from a 15-entry gray-level table.

Before the table lookup, each column's 4-bit pixel code passes through a display-mode stage. That stage can pass the code unchanged, force every column fully on, force every column off, or invert the code. The block also counts rows. It pulses a row strobe at the start of every row and a frame strobe when the row count wraps. All configuration, including the table contents seen by the lookup, is captured only at the start of a row. A row already running is never disturbed by a configuration change. Analog levels are outside this block.

Top module: `gsrow_seq`

## Requirements
- R1: After reset, and until the first display-clock tick, every phase output, column output and strobe is low. The table then holds entry n = n for levels 1 to 15.
- R2: A display-clock tick occurs on every (cfg_div + 1)-th osc_tick. The row position advances only on display-clock ticks.
- R3: The reset phase lasts cfg_phase[3:0] + 1 display clocks from row start, and the first pre-charge lasts cfg_phase[7:4] + 1 display clocks after it. At most one of the four phase outputs is high at a time.
- R4: The second pre-charge lasts cfg_pc2 display clocks (0 to 15) after the first pre-charge. A value of 0 skips the phase.
- R5: A row lasts cfg_row_clks display clocks. Values below 20 are treated as 20. row_stb is high for one clk cycle as each row starts.
- R6: col_en[c] is high only in the current-drive phase, for the first T display clocks of that phase, where T is the table entry for the column's effective level. A level of 0 never raises col_en or col_pc. col_pc[c] follows the two pre-charge phases for non-zero levels.
- R7: If the table count is longer than the current-drive phase, col_en ends with the row.
- R8: cfg_mode 0 uses the pixel code as is, 1 forces level 15, 2 forces level 0, and 3 uses 15 minus the code.
- R9: A frame has cfg_mux + 1 rows, where values below 15 are treated as 15. frame_stb pulses together with row_stb at the first row and at every row-count wrap.
- R10: Configuration inputs, pixel codes, mode and table contents take effect only at a row start. A change mid-row leaves that row unchanged.
- R11: A write with lut_we high and lut_addr in 1 to 15 replaces that level's 6-bit entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | Oscillator tick, one clk wide |
| cfg_div | input | 4 | Display-clock divide ratio minus one |
| cfg_phase | input | 8 | [3:0] reset length minus one, [7:4] first pre-charge length minus one |
| cfg_pc2 | input | 4 | Second pre-charge length |
| cfg_row_clks | input | 7 | Display clocks per row |
| cfg_mux | input | 7 | Rows per frame minus one |
| cfg_mode | input | 2 | 0 normal, 1 all on, 2 all off, 3 inverse |
| lut_we | input | 1 | Table write strobe |
| lut_addr | input | 4 | Gray level being written |
| lut_data | input | 6 | Drive length in display clocks |
| pix_codes | input | 16 | Per-column 4-bit pixel codes, column c at [4c+3:4c] |
| ph_reset | output | 1 | Reset phase active |
| ph_pre1 | output | 1 | First pre-charge active |
| ph_pre2 | output | 1 | Second pre-charge active |
| ph_drive | output | 1 | Current-drive phase active |
| col_pc | output | 4 | Per-column pre-charge enable |
| col_en | output | 4 | Per-column current-drive enable |
| row_stb | output | 1 | Row start strobe |
| frame_stb | output | 1 | Frame start strobe |

## Verification
The hardest case to reach is a table entry that outlasts the drive phase. That case needs short pre-charge settings, a clamped short row and a large table write, all in effect together in one latched row. The bench writes the table, sets a 5-clock row request and zero phase lengths, waits one row boundary for the latch, and then counts enable cycles across a full row. A mid-row configuration change is reached by driving the new value on the exact cycle the row strobe is seen. The bench then measures the next two row lengths.

// File: rtl/gsrow_pkg.sv
package gsrow_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'd0,
    MODE_ALL_ON  = 2'd1,
    MODE_ALL_OFF = 2'd2,
    MODE_INVERT  = 2'd3
  } gs_mode_e;

  localparam int DEF_RST_CLKS = 4;
  localparam int DEF_PC1_CLKS = 6;
endpackage

// File: rtl/gsrow_clkdiv.sv
module gsrow_clkdiv #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             osc_tick,
  input  logic [DIV_W-1:0] div_ratio,
  output logic             dclk_tick
);
  logic [DIV_W-1:0] cnt_q;

  assign dclk_tick = osc_tick && (cnt_q >= div_ratio);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (osc_tick) begin
      cnt_q <= dclk_tick ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/gsrow_lut.sv
module gsrow_lut #(
  parameter int GW    = 4,
  parameter int LUT_W = 6,
  parameter int NRD   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [GW-1:0]      waddr,
  input  logic [LUT_W-1:0]   wdata,
  input  logic [NRD*GW-1:0]  raddr,
  output logic [NRD*LUT_W-1:0] rdata
);
  localparam int NENT = 1 << GW;

  logic [LUT_W-1:0] tab_q [NENT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NENT; i++) tab_q[i] <= LUT_W'(i);
    end else if (we && (waddr != '0)) begin
      tab_q[waddr] <= wdata;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    logic [GW-1:0] idx;
    assign idx = raddr[r*GW +: GW];
    assign rdata[r*LUT_W +: LUT_W] = (idx == '0) ? '0 : tab_q[idx];
  end
endmodule

// File: rtl/gsrow_pixmap.sv
module gsrow_pixmap
  import gsrow_pkg::*;
#(
  parameter int GW = 4
) (
  input  logic [GW-1:0] code,
  input  gs_mode_e      mode,
  output logic [GW-1:0] level
);
  always_comb begin
    unique case (mode)
      MODE_ALL_ON:  level = '1;
      MODE_ALL_OFF: level = '0;
      MODE_INVERT:  level = ~code;
      default:      level = code;
    endcase
  end
endmodule

// File: rtl/gsrow_seq.sv
module gsrow_seq
  import gsrow_pkg::*;
#(
  parameter int NCOL    = 4,
  parameter int GW      = 4,
  parameter int LUT_W   = 6,
  parameter int DIV_W   = 4,
  parameter int PH_W    = 4,
  parameter int ROW_W   = 7,
  parameter int MUX_W   = 7,
  parameter int ROW_MIN = 20,
  parameter int MUX_MIN = 15
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 osc_tick,
  input  logic [DIV_W-1:0]     cfg_div,
  input  logic [2*PH_W-1:0]    cfg_phase,
  input  logic [PH_W-1:0]      cfg_pc2,
  input  logic [ROW_W-1:0]     cfg_row_clks,
  input  logic [MUX_W-1:0]     cfg_mux,
  input  logic [1:0]           cfg_mode,
  input  logic                 lut_we,
  input  logic [GW-1:0]        lut_addr,
  input  logic [LUT_W-1:0]     lut_data,
  input  logic [NCOL*GW-1:0]   pix_codes,
  output logic                 ph_reset,
  output logic                 ph_pre1,
  output logic                 ph_pre2,
  output logic                 ph_drive,
  output logic [NCOL-1:0]      col_pc,
  output logic [NCOL-1:0]      col_en,
  output logic                 row_stb,
  output logic                 frame_stb
);
  localparam int SUM_W = PH_W + 3;
  localparam int CMP_W = (ROW_W > SUM_W) ? ROW_W : SUM_W;

  // latched row configuration
  logic [DIV_W-1:0]     div_q;
  logic [PH_W:0]        p1_q, p2_q;
  logic [PH_W-1:0]      p3_q;
  logic [ROW_W-1:0]     len_q;
  logic [MUX_W-1:0]     rows_m1_q;
  logic [NCOL*GW-1:0]   lvl_q;
  logic [NCOL*LUT_W-1:0] wid_q;

  // row state
  logic             first_q;
  logic [ROW_W-1:0] pos_q;
  logic [MUX_W-1:0] row_q;
  logic             row_stb_q, frame_stb_q;

  logic                  dtick;
  logic [NCOL*GW-1:0]    lvl_now;
  logic [NCOL*LUT_W-1:0] wid_now;

  gsrow_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .osc_tick (osc_tick),
    .div_ratio(div_q),
    .dclk_tick(dtick)
  );

  for (genvar c = 0; c < NCOL; c++) begin : g_map
    gsrow_pixmap #(.GW(GW)) u_map (
      .code (pix_codes[c*GW +: GW]),
      .mode (gs_mode_e'(cfg_mode)),
      .level(lvl_now[c*GW +: GW])
    );
  end

  gsrow_lut #(.GW(GW), .LUT_W(LUT_W), .NRD(NCOL)) u_lut (
    .clk  (clk),
    .rst  (rst),
    .we   (lut_we),
    .waddr(lut_addr),
    .wdata(lut_data),
    .raddr(lvl_now),
    .rdata(wid_now)
  );

  logic             row_end, start, wrap;
  logic [ROW_W-1:0] len_in;
  logic [MUX_W-1:0] rows_in;

  assign row_end = (pos_q == len_q - 1'b1);
  assign start   = dtick && (first_q || row_end);
  assign wrap    = first_q || (row_q == rows_m1_q);
  assign len_in  = (cfg_row_clks < ROW_W'(ROW_MIN)) ? ROW_W'(ROW_MIN) : cfg_row_clks;
  assign rows_in = (cfg_mux < MUX_W'(MUX_MIN)) ? MUX_W'(MUX_MIN) : cfg_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q     <= 1'b1;
      pos_q       <= '0;
      row_q       <= '0;
      len_q       <= ROW_W'(ROW_MIN);
      rows_m1_q   <= '1;
      div_q       <= '0;
      p1_q        <= (PH_W+1)'(DEF_RST_CLKS);
      p2_q        <= (PH_W+1)'(DEF_PC1_CLKS);
      p3_q        <= '0;
      lvl_q       <= '0;
      wid_q       <= '0;
      row_stb_q   <= 1'b0;
      frame_stb_q <= 1'b0;
    end else begin
      row_stb_q   <= start;
      frame_stb_q <= start && wrap;
      if (start) begin
        first_q   <= 1'b0;
        pos_q     <= '0;
        row_q     <= wrap ? '0 : row_q + 1'b1;
        len_q     <= len_in;
        rows_m1_q <= rows_in;
        div_q     <= cfg_div;
        p1_q      <= {1'b0, cfg_phase[PH_W-1:0]} + 1'b1;
        p2_q      <= {1'b0, cfg_phase[2*PH_W-1:PH_W]} + 1'b1;
        p3_q      <= cfg_pc2;
        lvl_q     <= lvl_now;
        wid_q     <= wid_now;
      end else if (dtick) begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  // phase decode from registered row state
  logic [CMP_W-1:0] t1, t2, t3, posx, doff;
  assign t1   = CMP_W'(p1_q);
  assign t2   = t1 + CMP_W'(p2_q);
  assign t3   = t2 + CMP_W'(p3_q);
  assign posx = CMP_W'(pos_q);
  assign doff = posx - t3;

  assign ph_reset = !first_q && (posx < t1);
  assign ph_pre1  = !first_q && (posx >= t1) && (posx < t2);
  assign ph_pre2  = !first_q && (posx >= t2) && (posx < t3);
  assign ph_drive = !first_q && (posx >= t3);

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    logic lit;
    assign lit       = (lvl_q[c*GW +: GW] != '0);
    assign col_pc[c] = lit && (ph_pre1 || ph_pre2);
    assign col_en[c] = lit && ph_drive && (CMP_W'(wid_q[c*LUT_W +: LUT_W]) > doff);
  end

  assign row_stb   = row_stb_q;
  assign frame_stb = frame_stb_q;
endmodule

// File: rtl/gsrow_seq_chk.sv
module gsrow_seq_chk #(
  parameter int NCOL = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            ph_reset,
  input logic            ph_pre1,
  input logic            ph_pre2,
  input logic            ph_drive,
  input logic [NCOL-1:0] col_pc,
  input logic [NCOL-1:0] col_en,
  input logic            row_stb,
  input logic            frame_stb
);
  p_one_phase_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ph_reset, ph_pre1, ph_pre2, ph_drive}));

  p_row_opens_reset_r3: assert property (@(posedge clk) disable iff (rst)
    row_stb |-> ph_reset);

  p_strobe_single_r5: assert property (@(posedge clk) disable iff (rst)
    row_stb |=> !row_stb);

  p_en_in_drive_r6: assert property (@(posedge clk) disable iff (rst)
    (|col_en) |-> ph_drive);

  p_pc_in_precharge_r6: assert property (@(posedge clk) disable iff (rst)
    (|col_pc) |-> (ph_pre1 || ph_pre2));

  p_frame_on_row_r9: assert property (@(posedge clk) disable iff (rst)
    frame_stb |-> row_stb);
endmodule

bind gsrow_seq gsrow_seq_chk #(.NCOL(NCOL)) u_gsrow_chk (
  .clk      (clk),
  .rst      (rst),
  .ph_reset (ph_reset),
  .ph_pre1  (ph_pre1),
  .ph_pre2  (ph_pre2),
  .ph_drive (ph_drive),
  .col_pc   (col_pc),
  .col_en   (col_en),
  .row_stb  (row_stb),
  .frame_stb(frame_stb)
);

// File: tb/gsrow_seq_bench.sv
`timescale 1ns/1ps
module gsrow_seq_bench;
  localparam int NCOL = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic osc_tick = 1'b0;
  logic [3:0] cfg_div = 4'd0;
  logic [7:0] cfg_phase = 8'h21;
  logic [3:0] cfg_pc2 = 4'd2;
  logic [6:0] cfg_row_clks = 7'd24;
  logic [6:0] cfg_mux = 7'd15;
  logic [1:0] cfg_mode = 2'd0;
  logic lut_we = 1'b0;
  logic [3:0] lut_addr = 4'd0;
  logic [5:0] lut_data = 6'd0;
  logic [15:0] pix_codes = {4'd15, 4'd9, 4'd3, 4'd0};
  logic ph_reset, ph_pre1, ph_pre2, ph_drive, row_stb, frame_stb;
  logic [NCOL-1:0] col_pc, col_en;

  always #5 clk = ~clk;

  gsrow_seq u_gsrow_seq (
    .clk(clk), .rst(rst), .osc_tick(osc_tick), .cfg_div(cfg_div),
    .cfg_phase(cfg_phase), .cfg_pc2(cfg_pc2), .cfg_row_clks(cfg_row_clks),
    .cfg_mux(cfg_mux), .cfg_mode(cfg_mode), .lut_we(lut_we),
    .lut_addr(lut_addr), .lut_data(lut_data), .pix_codes(pix_codes),
    .ph_reset(ph_reset), .ph_pre1(ph_pre1), .ph_pre2(ph_pre2),
    .ph_drive(ph_drive), .col_pc(col_pc), .col_en(col_en),
    .row_stb(row_stb), .frame_stb(frame_stb)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;
  int cyc = 0;
  int osc_pat = 2;   // 0 every clk, 1 every other clk, 2 never
  int osc_ph = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_tb();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_first, m_pos, m_row, m_dcnt, m_div, m_p1, m_p2, m_p3, m_len, m_rows;
  int m_rs, m_fs;
  int m_lut[16];
  int m_lvl[NCOL];
  int m_w[NCOL];

  always @(posedge clk) begin
    if (rst) begin
      m_first = 1; m_pos = 0; m_row = 0; m_dcnt = 0; m_div = 0;
      m_p1 = 4; m_p2 = 6; m_p3 = 0; m_len = 20; m_rows = 128;
      m_rs = 0; m_fs = 0;
      for (int i = 0; i < 16; i++) m_lut[i] = i;
      for (int c = 0; c < NCOL; c++) begin m_lvl[c] = 0; m_w[c] = 0; end
      cmp_on = 1'b1;
    end else begin
      bit tick;
      tick = osc_tick && (m_dcnt >= m_div);
      if (osc_tick) m_dcnt = tick ? 0 : m_dcnt + 1;
      m_rs = 0; m_fs = 0;
      if (tick) begin
        if (m_first == 1 || m_pos == m_len - 1) begin
          m_fs = (m_first == 1 || m_row == m_rows - 1) ? 1 : 0;
          m_row = m_fs ? 0 : m_row + 1;
          m_rs = 1; m_pos = 0; m_first = 0;
          m_div = cfg_div;
          m_p1 = cfg_phase[3:0] + 1;
          m_p2 = cfg_phase[7:4] + 1;
          m_p3 = cfg_pc2;
          m_len = (cfg_row_clks < 20) ? 20 : cfg_row_clks;
          m_rows = ((cfg_mux < 15) ? 15 : cfg_mux) + 1;
          for (int c = 0; c < NCOL; c++) begin
            int code, lv;
            code = pix_codes[c*4 +: 4];
            case (cfg_mode)
              2'd1: lv = 15;
              2'd2: lv = 0;
              2'd3: lv = 15 - code;
              default: lv = code;
            endcase
            m_lvl[c] = lv;
            m_w[c] = (lv == 0) ? 0 : m_lut[lv];
          end
        end else begin
          m_pos = m_pos + 1;
        end
      end
      if (lut_we && lut_addr != 0) m_lut[lut_addr] = lut_data;
    end
  end

  // oscillator pattern and per-cycle comparison
  always @(negedge clk) begin
    cyc++;
    osc_ph = 1 - osc_ph;
    case (osc_pat)
      0: osc_tick = 1'b1;
      1: osc_tick = (osc_ph == 1);
      default: osc_tick = 1'b0;
    endcase
    if (cyc > 150000 && !done) begin
      chk(1'b0, "watchdog", cyc, 150000);
      finish_tb();
    end
    if (cmp_on && !done) begin
      int a, b, c3;
      bit live, e_r, e_1, e_2, e_d;
      live = (m_first == 0);
      a = m_p1; b = m_p1 + m_p2; c3 = b + m_p3;
      e_r = live && m_pos < a;
      e_1 = live && m_pos >= a && m_pos < b;
      e_2 = live && m_pos >= b && m_pos < c3;
      e_d = live && m_pos >= c3;
      chk(ph_reset == e_r, "R3 ph_reset", ph_reset, e_r);
      chk(ph_pre1 == e_1, "R3 ph_pre1", ph_pre1, e_1);
      chk(ph_pre2 == e_2, "R4 ph_pre2", ph_pre2, e_2);
      chk(ph_drive == e_d, "R6 ph_drive", ph_drive, e_d);
      for (int c = 0; c < NCOL; c++) begin
        bit en_e, pc_e;
        pc_e = (e_1 || e_2) && m_lvl[c] != 0;
        en_e = e_d && m_lvl[c] != 0 && (m_pos - c3) < m_w[c];
        chk(col_pc[c] == pc_e, "R6 col_pc", col_pc[c], pc_e);
        chk(col_en[c] == en_e, "R7 col_en", col_en[c], en_e);
      end
      chk(row_stb == m_rs[0], "R5 row_stb", row_stb, m_rs);
      chk(frame_stb == m_fs[0], "R9 frame_stb", frame_stb, m_fs);
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic next_row(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!row_stb && n < 20000);
  endtask

  task automatic next_frame(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!frame_stb && n < 40000);
  endtask

  function automatic bit pick(input int which);
    case (which)
      0: return ph_reset;
      1: return ph_pre1;
      2: return ph_pre2;
      default: return col_en[which-3];
    endcase
  endfunction

  // call while sitting on a row_stb cycle; ends on the next one
  task automatic row_count(input int which, output int cnt);
    int guard;
    cnt = pick(which);
    guard = 0;
    do begin
      @(negedge clk); guard++;
      if (!row_stb) cnt += pick(which);
    end while (!row_stb && guard < 20000);
  endtask

  task automatic lut_write(input int addr, input int data);
    @(negedge clk);
    lut_we = 1'b1; lut_addr = addr[3:0]; lut_data = data[5:0];
    @(negedge clk);
    lut_we = 1'b0;
  endtask

  initial begin
    int g, n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    // R1: no display tick yet, everything idle
    chk({ph_reset, ph_pre1, ph_pre2, ph_drive, row_stb, frame_stb} == 6'b0,
        "R1 idle phases", {ph_reset, ph_pre1, ph_pre2, ph_drive}, 0);
    chk(col_en == '0 && col_pc == '0, "R1 idle columns", col_en, 0);

    osc_pat = 0;
    next_row(g);
    row_count(0, n); chk(n == 2, "R3 reset length", n, 2);
    row_count(1, n); chk(n == 3, "R3 pre1 length", n, 3);
    row_count(2, n); chk(n == 2, "R4 pre2 length", n, 2);
    row_count(4, n); chk(n == 3, "R6 level3 default table", n, 3);
    next_frame(g);
    next_frame(g);
    chk(g == 16*24, "R9 frame spacing", g, 16*24);

    // short rows, big table entries
    cfg_phase = 8'h00; cfg_pc2 = 4'd0; cfg_row_clks = 7'd5;
    lut_write(15, 63);
    lut_write(9, 40);
    next_row(g);   // R10: new values latched here
    next_row(g);
    chk(g == 20, "R5 clamped row length", g, 20);
    row_count(6, n); chk(n == 18, "R7 level15 truncated", n, 18);
    row_count(5, n); chk(n == 18, "R11 level9 written entry", n, 18);
    row_count(4, n); chk(n == 3, "R6 level3 width", n, 3);
    row_count(3, n); chk(n == 0, "R6 level0 silent", n, 0);

    cfg_mode = 2'd1; next_row(g);
    row_count(3, n); chk(n == 18, "R8 all-on col0", n, 18);
    cfg_mode = 2'd2; next_row(g);
    row_count(6, n); chk(n == 0, "R8 all-off col3", n, 0);
    cfg_mode = 2'd3; next_row(g);
    row_count(3, n); chk(n == 18, "R8 invert code0", n, 18);
    row_count(5, n); chk(n == 6, "R8 invert code9", n, 6);
    row_count(6, n); chk(n == 0, "R8 invert code15", n, 0);
    cfg_mode = 2'd0;

    // R10: change on the strobe cycle, row in flight keeps old length
    next_row(g);
    cfg_row_clks = 7'd30;
    next_row(g); chk(g == 20, "R10 row unchanged", g, 20);
    next_row(g); chk(g == 30, "R10 next row new", g, 30);

    cfg_pc2 = 4'd15; next_row(g);
    row_count(2, n); chk(n == 15, "R4 pre2 max", n, 15);

    cfg_pc2 = 4'd0; cfg_div = 4'd2; next_row(g);
    next_row(g); chk(g == 90, "R2 divide by three", g, 90);
    osc_pat = 1; next_row(g);
    next_row(g); chk(g == 180, "R2 sparse oscillator", g, 180);

    cfg_mux = 7'd3; next_frame(g);
    next_frame(g);
    chk(g == 16*180, "R9 clamped frame", g, 16*180);

    osc_pat = 0; cfg_div = 4'd0; cfg_phase = 8'hff; cfg_pc2 = 4'd15;
    cfg_row_clks = 7'd127; cfg_mode = 2'd1;
    next_row(g);
    next_row(g); chk(g == 127, "R5 long row", g, 127);
    row_count(3, n); chk(n == 63, "R7 full width fits", n, 63);
    repeat (10) @(negedge clk);
    finish_tb();
  end
endmodule